// File: doc/BRIEF.md
# BCD Clock and Calendar Core

This block keeps wall-clock time and a calendar date in binary-coded decimal. Seven byte-wide registers hold the seconds, minutes, hours, day of the week, day of the month, month and two-digit year. A host loads any of them through a single-cycle write port and reads them back through a combinational read port. A one-cycle `tick` pulse, supplied once per second by whatever time base the chip has, advances the time by one second.

An advance is carried out by a small sequencer. On a tick it steps the seconds. While a field wraps, the carry moves on to the next field, one field per clock: minutes, then hours, then day-of-week and date together, then month, then year. When the year wraps from 99 to 00, the most significant bit of the month register flips and serves as a century marker. The hours field is stored either as a 24-hour count or as a 12-hour count with an afternoon flag. Bit 6 of the value written chooses the form, and every later step keeps it.

The sequencer has the states IDLE, SEC, MIN, HOUR, DAY, MONTH and YEAR. A tick moves IDLE to SEC. Each stepping state goes to the next state when its field wraps, and otherwise back to IDLE. YEAR always returns to IDLE.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 00h, minutes 00h, hours 00h (24-hour form), day-of-week 01h, date 01h, month 01h with the century bit clear, and year 00h.
- R2: Seconds (address 0) and minutes (address 1) count 00 to 59 in BCD. A wrap from 59 to 00 carries into the next field.
- R3: With hours bit 6 at 0, hours (address 2) count 00 to 23 in BCD. Bits 5:4 hold the tens digit. The step from 23 to 00 starts a new day.
- R4: With hours bit 6 at 1, bits 4:0 count 12, 01, ..., 11 in BCD and bit 5 marks PM. Bit 5 flips on each step from 11 to 12, and the step from 11 PM to 12 AM starts a new day. Bit 6 is never changed by a step.
- R5: Day-of-week (address 3) increments on each new day and wraps from 07 to 01.
- R6: Date (address 4) wraps to 01 after the last day of the month and carries into the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R7: Month (address 5, bits 4:0) wraps from 12 to 01 and carries into the year (address 6). The year wraps from 99 to 00 and then flips month bit 7 (the century bit).
- R8: A write changes the addressed register at the next clock edge. It wins over a step of that field in the same cycle.
- R9: The read port returns the addressed register in the same cycle. Address 7 reads 00h and ignores writes. Unused bits read 0: seconds and minutes bit 7, hours bit 7, day-of-week bits 7:3, date bits 7:6, and month bits 6:5.
- R10: After a tick, every field is settled within 7 clock cycles. A tick that arrives while an advance is still in progress is ignored, and no register changes while the sequencer is idle unless it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data (BCD) |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data for `rd_addr` |

## Verification
The bench builds the core with its default week length of seven days, which is the only parameter. With that value, every date rollover, including the day-of-week wrap, can be compared against a calendar model that the bench computes with plain integer arithmetic. The directed cases reach leap and non-leap February ends, the ends of 30-day months, the 12-hour noon and midnight steps, and the year 99 wrap with the century bit. The random loads start near those edges and cover both hour forms. A long run of consecutive ticks walks through the minute and hour carries.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEC   = 3'd1,
        ST_MIN   = 3'd2,
        ST_HOUR  = 3'd3,
        ST_DAY   = 3'd4,
        ST_MONTH = 3'd5,
        ST_YEAR  = 3'd6
    } seq_state_e;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

    localparam logic [REG_W-1:0] M_SEC  = 8'h7F;
    localparam logic [REG_W-1:0] M_MIN  = 8'h7F;
    localparam logic [REG_W-1:0] M_HOUR = 8'h7F;
    localparam logic [REG_W-1:0] M_DOW  = 8'h07;
    localparam logic [REG_W-1:0] M_DATE = 8'h3F;
    localparam logic [REG_W-1:0] M_MON  = 8'h9F;
    localparam logic [REG_W-1:0] M_YEAR = 8'hFF;

    // add one to a two-digit BCD byte
    function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // a BCD year is a multiple of four when (2*tens + ones) is
    function automatic logic year_is_leap(input logic [REG_W-1:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [REG_W-1:0] month_last_day(input logic [4:0] mon,
                                                         input logic [REG_W-1:0] y);
        logic [REG_W-1:0] r;
        unique case (mon)
            5'h02:                      r = year_is_leap(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] lo,
    input  logic [REG_W-1:0] hi,
    output logic [REG_W-1:0] nxt,
    output logic             wrap
);
    always_comb begin
        wrap = (cur == hi);
        nxt  = wrap ? lo : bcd_inc(cur);
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [6:0] cur,
    output logic [6:0] nxt,
    output logic       day_wrap
);
    logic [REG_W-1:0] hv;
    logic [REG_W-1:0] hinc;

    always_comb begin
        if (cur[6]) hv = {3'b000, cur[4:0]};
        else        hv = {2'b00, cur[5:0]};
        hinc = bcd_inc(hv);
        day_wrap = 1'b0;
        if (cur[6]) begin
            if (hv == 8'h12) begin
                nxt = {1'b1, cur[5], 5'h01};
            end else if (hv == 8'h11) begin
                nxt      = {1'b1, ~cur[5], 5'h12};
                day_wrap = cur[5];
            end else begin
                nxt = {1'b1, cur[5], hinc[4:0]};
            end
        end else begin
            if (hv == 8'h23) begin
                nxt      = 7'h00;
                day_wrap = 1'b1;
            end else begin
                nxt = {1'b0, hinc[5:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sec_wrap,
    input  logic       min_wrap,
    input  logic       day_wrap,
    input  logic       date_wrap,
    input  logic       mon_wrap,
    output seq_state_e state,
    output logic       en_sec,
    output logic       en_min,
    output logic       en_hour,
    output logic       en_day,
    output logic       en_mon,
    output logic       en_year
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state <= tick      ? ST_SEC   : ST_IDLE;
                ST_SEC:   state <= sec_wrap  ? ST_MIN   : ST_IDLE;
                ST_MIN:   state <= min_wrap  ? ST_HOUR  : ST_IDLE;
                ST_HOUR:  state <= day_wrap  ? ST_DAY   : ST_IDLE;
                ST_DAY:   state <= date_wrap ? ST_MONTH : ST_IDLE;
                ST_MONTH: state <= mon_wrap  ? ST_YEAR  : ST_IDLE;
                ST_YEAR:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        en_sec  = 1'b0;
        en_min  = 1'b0;
        en_hour = 1'b0;
        en_day  = 1'b0;
        en_mon  = 1'b0;
        en_year = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SEC:   en_sec  = 1'b1;
            ST_MIN:   en_min  = 1'b1;
            ST_HOUR:  en_hour = 1'b1;
            ST_DAY:   en_day  = 1'b1;
            ST_MONTH: en_mon  = 1'b1;
            ST_YEAR:  en_year = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter logic [REG_W-1:0] DOW_LAST = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data
);
    logic [REG_W-1:0] r_sec, r_min, r_hour, r_dow, r_date, r_mon, r_year;

    seq_state_e state;
    logic en_sec, en_min, en_hour, en_day, en_mon, en_year;
    logic sec_wrap, min_wrap, day_wrap, date_wrap, mon_wrap, year_wrap, dow_wrap;
    logic [REG_W-1:0] sec_nxt, min_nxt, dow_nxt, date_nxt, mon_nxt, year_nxt;
    logic [6:0]       hour_nxt;
    logic [REG_W-1:0] last_day;

    logic w_sec, w_min, w_hour, w_dow, w_date, w_mon, w_year;
    assign w_sec  = wr_en && (wr_addr == A_SEC);
    assign w_min  = wr_en && (wr_addr == A_MIN);
    assign w_hour = wr_en && (wr_addr == A_HOUR);
    assign w_dow  = wr_en && (wr_addr == A_DOW);
    assign w_date = wr_en && (wr_addr == A_DATE);
    assign w_mon  = wr_en && (wr_addr == A_MON);
    assign w_year = wr_en && (wr_addr == A_YEAR);

    assign last_day = month_last_day(r_mon[4:0], r_year);

    rtc_bcd_step u_sec  (.cur(r_sec),  .lo(8'h00), .hi(8'h59),   .nxt(sec_nxt),  .wrap(sec_wrap));
    rtc_bcd_step u_min  (.cur(r_min),  .lo(8'h00), .hi(8'h59),   .nxt(min_nxt),  .wrap(min_wrap));
    rtc_hour_step u_hour (.cur(r_hour[6:0]), .nxt(hour_nxt), .day_wrap(day_wrap));
    rtc_bcd_step u_dow  (.cur(r_dow),  .lo(8'h01), .hi(DOW_LAST), .nxt(dow_nxt),  .wrap(dow_wrap));
    rtc_bcd_step u_date (.cur(r_date), .lo(8'h01), .hi(last_day), .nxt(date_nxt), .wrap(date_wrap));
    rtc_bcd_step u_mon  (.cur({3'b000, r_mon[4:0]}), .lo(8'h01), .hi(8'h12),
                         .nxt(mon_nxt), .wrap(mon_wrap));
    rtc_bcd_step u_year (.cur(r_year), .lo(8'h00), .hi(8'h99),   .nxt(year_nxt), .wrap(year_wrap));

    rtc_seq_fsm u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sec_wrap (sec_wrap),
        .min_wrap (min_wrap),
        .day_wrap (day_wrap),
        .date_wrap(date_wrap),
        .mon_wrap (mon_wrap),
        .state    (state),
        .en_sec   (en_sec),
        .en_min   (en_min),
        .en_hour  (en_hour),
        .en_day   (en_day),
        .en_mon   (en_mon),
        .en_year  (en_year)
    );

    // each field: write first, then the sequencer step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_sec  <= 8'h00;
            r_min  <= 8'h00;
            r_hour <= 8'h00;
            r_dow  <= 8'h01;
            r_date <= 8'h01;
            r_mon  <= 8'h01;
            r_year <= 8'h00;
        end else begin
            if (w_sec)       r_sec <= wr_data & M_SEC;
            else if (en_sec) r_sec <= sec_nxt;

            if (w_min)       r_min <= wr_data & M_MIN;
            else if (en_min) r_min <= min_nxt;

            if (w_hour)       r_hour <= wr_data & M_HOUR;
            else if (en_hour) r_hour <= {1'b0, hour_nxt};

            if (w_dow)       r_dow <= wr_data & M_DOW;
            else if (en_day) r_dow <= dow_nxt;

            if (w_date)      r_date <= wr_data & M_DATE;
            else if (en_day) r_date <= date_nxt;

            if (w_mon) begin
                r_mon <= wr_data & M_MON;
            end else begin
                if (en_mon)                          r_mon[4:0] <= mon_nxt[4:0];
                if (en_year && year_wrap && !w_year) r_mon[7]   <= ~r_mon[7];
            end

            if (w_year)       r_year <= wr_data & M_YEAR;
            else if (en_year) r_year <= year_nxt;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_SEC:   rd_data = r_sec;
            A_MIN:   rd_data = r_min;
            A_HOUR:  rd_data = r_hour;
            A_DOW:   rd_data = r_dow;
            A_DATE:  rd_data = r_date;
            A_MON:   rd_data = r_mon;
            A_YEAR:  rd_data = r_year;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input seq_state_e        state,
    input logic [REG_W-1:0]  r_sec,
    input logic [REG_W-1:0]  r_min,
    input logic [REG_W-1:0]  r_hour,
    input logic [REG_W-1:0]  r_dow,
    input logic [REG_W-1:0]  r_date,
    input logic [REG_W-1:0]  r_mon,
    input logic [REG_W-1:0]  r_year
);
    // R8: a write to seconds lands even while seconds are being stepped
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SEC) |=> (r_sec == ($past(wr_data) & 8'h7F)));

    // R7: the year wrap flips the century bit
    assert_century_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_YEAR && r_year == 8'h99 && !(wr_en && (wr_addr == A_YEAR || wr_addr == A_MON)))
        |=> (r_mon[7] != $past(r_mon[7])));

    // R2: the seconds stage always moves the seconds
    assert_sec_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEC && !(wr_en && wr_addr == A_SEC)) |=> (r_sec != $past(r_sec)));

    // R4: a step never changes the hour form bit
    assert_hour_form_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOUR && !(wr_en && wr_addr == A_HOUR)) |=> (r_hour[6] == $past(r_hour[6])));

    // R5: day-of-week stays within 1..7
    assert_dow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_dow >= 8'h01 && r_dow <= 8'h07));

    // R10: nothing changes while idle and not written
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wr_en) |=> ($stable(r_sec) && $stable(r_min) && $stable(r_hour)
            && $stable(r_dow) && $stable(r_date) && $stable(r_mon) && $stable(r_year)));

    // R6: a month step happens only after the date wrapped to 01
    assert_month_after_date_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MONTH && !(wr_en && wr_addr == A_DATE)) |-> (r_date == 8'h01));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .state  (state),
    .r_sec  (r_sec),
    .r_min  (r_min),
    .r_hour (r_hour),
    .r_dow  (r_dow),
    .r_date (r_date),
    .r_mon  (r_mon),
    .r_year (r_year)
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    rtc_calendar_core u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // calendar model in plain integers; hour kept 0..23
    int ms, mm, mh, mdow, md, mmo, my;
    bit m12, mcen;

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int days_of(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_code(int h, bit is12);
        int h12;
        if (!is12) return to_bcd(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return 8'h40 | (h >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
    endfunction

    function automatic logic [7:0] exp_reg(int a);
        case (a)
            0: return to_bcd(ms);
            1: return to_bcd(mm);
            2: return hour_code(mh, m12);
            3: return to_bcd(mdow);
            4: return to_bcd(md);
            5: return (mcen ? 8'h80 : 8'h00) | to_bcd(mmo);
            6: return to_bcd(my);
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_tick();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mdow = (mdow == 7) ? 1 : mdow + 1;
                    md++;
                    if (md > days_of(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my++;
                            if (my == 100) begin
                                my = 0; mcen = !mcen;
                            end
                        end
                    end
                end
            end
        end
    endfunction

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(int s, int m, int h, bit is12, int dw, int d, int mo, int y, bit c);
        ms = s; mm = m; mh = h; m12 = is12; mdow = dw; md = d; mmo = mo; my = y; mcen = c;
        for (int a = 0; a < 7; a++) write_reg(3'(a), exp_reg(a));
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        repeat (8) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            n_vec++;
            if (rd_data !== exp_reg(a)) begin
                n_bad++;
                $display("FAIL %s addr %0d: got %02h expected %02h", tag, a, rd_data, exp_reg(a));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seedv;
        seedv = $urandom(32'd2024);
        ms = 0; mm = 0; mh = 0; m12 = 0; mdow = 1; md = 1; mmo = 1; my = 0; mcen = 0;
        repeat (3) @(negedge clk);
        // R1 reset values, R9 address 7 reads zero
        check_all("R1 reset / R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R2 seconds and minutes carry
        set_time(59, 59, 4, 0, 3, 10, 5, 17, 0);
        do_tick(); check_all("R2 minute carry");
        // R3 24h midnight, R5 dow wrap 7->1
        set_time(59, 59, 23, 0, 7, 14, 7, 30, 0);
        do_tick(); check_all("R3 R5 midnight");
        // R4 12h: 11 AM -> 12 PM
        set_time(59, 59, 11, 1, 2, 3, 3, 3, 0);
        do_tick(); check_all("R4 noon");
        // R4 12h: 12 PM -> 1 PM
        set_time(59, 59, 12, 1, 2, 3, 3, 3, 0);
        do_tick(); check_all("R4 12 to 01");
        // R4 12h: 11 PM -> 12 AM new day
        set_time(59, 59, 23, 1, 6, 9, 9, 9, 1);
        do_tick(); check_all("R4 midnight");
        // R6 leap and non-leap February, 30-day month, year 00
        set_time(59, 59, 23, 0, 1, 28, 2, 24, 0);
        do_tick(); check_all("R6 leap feb28");
        set_time(59, 59, 23, 0, 1, 29, 2, 24, 0);
        do_tick(); check_all("R6 leap feb29");
        set_time(59, 59, 23, 0, 1, 28, 2, 23, 0);
        do_tick(); check_all("R6 common feb28");
        set_time(59, 59, 23, 0, 1, 28, 2, 0, 1);
        do_tick(); check_all("R6 year 00 leap");
        set_time(59, 59, 23, 0, 4, 30, 4, 51, 0);
        do_tick(); check_all("R6 april end");
        // R7 year and century
        set_time(59, 59, 23, 0, 5, 31, 12, 99, 0);
        do_tick(); check_all("R7 century set");
        set_time(59, 59, 23, 1, 5, 31, 12, 99, 1);
        do_tick(); check_all("R7 century clear");
        set_time(59, 59, 23, 0, 5, 31, 12, 45, 0);
        do_tick(); check_all("R7 new year");

        // R8 write during the seconds step wins
        set_time(10, 20, 5, 0, 2, 2, 2, 2, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h33;
        @(negedge clk); wr_en = 1'b0;
        ms = 33;
        repeat (8) @(negedge clk);
        check_all("R8 write priority");

        // R10 second tick during an advance is ignored
        set_time(59, 59, 7, 0, 2, 2, 2, 2, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        model_tick();
        repeat (8) @(negedge clk);
        check_all("R10 tick ignored");

        // R9 unused bits read zero, address 7 ignores writes
        set_time(0, 0, 0, 0, 1, 1, 1, 0, 0);
        write_reg(3'd3, 8'hF5); mdow = 5;
        write_reg(3'd7, 8'hAA);
        check_all("R9 masks");

        // random loads near the edges
        for (int it = 0; it < 60; it++) begin
            int s, m, h, mo, y, d;
            s  = ($urandom % 2) ? 55 + $urandom % 5 : $urandom % 60;
            m  = ($urandom % 2) ? 59 : $urandom % 60;
            h  = ($urandom % 2) ? 23 : $urandom % 24;
            mo = 1 + $urandom % 12;
            y  = ($urandom % 4 == 0) ? 99 : $urandom % 100;
            d  = ($urandom % 2) ? days_of(mo, y) : 1 + $urandom % days_of(mo, y);
            set_time(s, m, h, 1'($urandom), 1 + $urandom % 7, d, mo, y, 1'($urandom));
            for (int k = 0; k < 6; k++) begin
                do_tick(); check_all("R2 R3 R4 R5 R6 R7 random");
            end
        end

        // long run of consecutive ticks
        set_time(0, 58, 10, 1, 4, 15, 6, 12, 0);
        for (int k = 0; k < 2500; k++) begin
            do_tick(); check_all("R2 R4 run");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule